// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block sits beside a program counter and runs counted loops without any decrement, compare or branch instructions in the loop body. When the core fetches a loop-start command, it also presents the trip count and the address of the last instruction of the body. The block pushes a frame holding the count, the start address (the command's address plus one) and the end address onto a small stack. Loops may be nested.

On every accepted fetch the block compares the fetch address with the end address of the innermost active loop. If that loop still has passes left, the block redirects the next fetch to the loop's start address in the same cycle and decrements the count. On the final pass it signals expiry, pops the frame and lets fetch continue at the sequential address. When an expiring loop shares its end address with the enclosing loop, the enclosing loop's end check is applied in the same cycle.

A body shorter than a set minimum length cannot hide the redirect. After each redirect into such a body the block raises a stall for the missing cycles, and it ignores fetches while the stall lasts. The core must skip the loop itself when the trip count is zero. A loop-start command issued while the stack is full is refused and flagged.

Top module: `zol_sequencer`

## Requirements
- R1: After a synchronous active-low reset, loop_depth_o is 0 and redirect_o, expired_o and stall_o are all 0.
- R2: An accepted fetch with loop_start_i high pushes a frame with start = fetch_pc_i + 1 and the given count and end address, which raises loop_depth_o by one. Execution of the body begins at the instruction after the command.
- R3: When the innermost loop has a count above 1 and its end address is fetched, redirect_o is asserted in that same cycle with redirect_pc_o equal to the loop's start address, and the count is decremented.
- R4: A loop with trip count N executes its body exactly N times. On the end fetch of the last pass, expired_o is 1 and redirect_o is 0, the frame is popped and fetch continues at end + 1. Outside the end fetch, the loop adds no cycles.
- R5: A fetch whose address differs from the innermost loop's end address produces no redirect.
- R6: Loops nest. An inner loop runs all of its passes on every pass of the enclosing loop, and up to DEPTH (default 6) loops may be active at once.
- R7: A loop-start command while DEPTH loops are active (after any pops in that cycle) raises overflow_o and leaves the stack unchanged.
- R8: When the innermost loop expires on a fetch that is also the end address of the enclosing loop, the inner frame is popped and the enclosing loop redirects or expires in that same cycle.
- R9: If the body length (end - start + 1) is below MIN_BODY (default 3), each redirect is followed by MIN_BODY - length cycles with stall_o high. Bodies of MIN_BODY or more never stall.
- R10: While stall_o is high, fetch inputs are ignored: no redirect, no expiry, no push, no count change.
- R11: A trip count of 1 runs the body once, and expired_o is asserted on its first end fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid_i | input | 1 | A fetch takes place this cycle |
| fetch_pc_i | input | ADDR_W | Address being fetched |
| loop_start_i | input | 1 | The fetched instruction is a loop-start command |
| loop_count_i | input | CNT_W | Trip count of the new loop (non-zero) |
| loop_end_i | input | ADDR_W | Address of the last body instruction of the new loop |
| redirect_o | output | 1 | Next fetch must come from redirect_pc_o |
| redirect_pc_o | output | ADDR_W | Loop start address used for the redirect |
| expired_o | output | 1 | A loop counter expired on this fetch |
| stall_o | output | 1 | Pipeline refill after redirect into a short body |
| overflow_o | output | 1 | Loop-start refused because the stack is full |
| loop_depth_o | output | $clog2(DEPTH+1) | Number of active loops |

## Verification
On every cycle the assertions check that the depth stays within DEPTH, that a pop lowers the depth by exactly the number of frames released, and that a refused command leaves the depth unchanged. They also check that a redirect or expiry only happens with a loop active, that a redirect into a short body starts a stall, and that the stall counter steps down by one. Pass counts, start addresses, same-address nesting, the exact stall length and the cycle cost of a loop depend on whole instruction streams. Only the bench scenarios can show them: a small fetch model follows the redirects and counts visits per address, expiries and cycles.

// File: rtl/zol_pkg.sv
// Shared widths and the loop frame layout used by the sequencer.
// Assumes one address space for fetch and loop bounds.
package zol_pkg;
    parameter int ADDR_W = 16;
    parameter int CNT_W  = 16;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] start_addr;
        logic [ADDR_W-1:0] end_addr;
    } loop_frame_t;
endpackage

// File: rtl/zol_stack.sv
// Loop frame stack. It releases `pops` frames, optionally decrements the
// frame that is then on top, and optionally pushes a new frame, all in
// one cycle. Assumes the caller never pushes when full and only decrements
// when a frame survives.
module zol_stack
    import zol_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [SPW-1:0] pops,
    input  logic         dec_en,
    input  logic         push_en,
    input  loop_frame_t  push_frame,
    output loop_frame_t  frames [DEPTH],
    output logic [SPW-1:0] sp
);
    logic [SPW-1:0] base;
    assign base = sp - pops;

    // Stack pointer: pops first, then the optional push.
    always_ff @(posedge clk) begin
        if (!rst_n) sp <= '0;
        else        sp <= base + (push_en ? SPW'(1) : SPW'(0));
    end

    // Frame storage: decrement the surviving top, write the pushed frame.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (dec_en)  frames[base - SPW'(1)].count <= frames[base - SPW'(1)].count - 1'b1;
            if (push_en) frames[base] <= push_frame;
        end
    end

    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SPW'(DEPTH));

    a_r4_pop_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (pops != '0 && !push_en) |=> sp == $past(sp) - $past(pops));
endmodule

// File: rtl/zol_endcheck.sv
// End-address matcher. It walks the stack from the top and releases every
// expiring frame whose end address equals the fetch address, stopping at the
// first frame that redirects or does not match. Purely combinational.
module zol_endcheck
    import zol_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic              active,
    input  logic [ADDR_W-1:0] pc,
    input  loop_frame_t       frames [DEPTH],
    input  logic [SPW-1:0]    sp,
    output logic [SPW-1:0]    pops,
    output logic              redirect,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] body_len
);
    // Cascade through the nest levels, innermost first.
    always_comb begin
        logic           walking;
        logic [SPW-1:0] idx;
        walking  = active;
        pops     = '0;
        redirect = 1'b0;
        target   = '0;
        body_len = '0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (walking && (SPW'(k) < sp)) begin
                idx = sp - SPW'(1) - SPW'(k);
                if (frames[idx].end_addr == pc) begin
                    if (frames[idx].count == CNT_W'(1)) begin
                        pops = pops + SPW'(1);
                    end else begin
                        redirect = 1'b1;
                        target   = frames[idx].start_addr;
                        body_len = frames[idx].end_addr - frames[idx].start_addr + ADDR_W'(1);
                        walking  = 1'b0;
                    end
                end else begin
                    walking = 1'b0;
                end
            end else begin
                walking = 1'b0;
            end
        end
    end
endmodule

// File: rtl/zol_refill.sv
// Refill stall timer. After a redirect into a body shorter than MIN_BODY
// it holds the stall for MIN_BODY - length cycles.
module zol_refill
    import zol_pkg::*;
#(
    parameter int MIN_BODY = 3,
    localparam int SW      = $clog2(MIN_BODY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] body_len,
    output logic              stall
);
    logic [SW-1:0] remain;
    logic          short_body;

    assign short_body = (int'(body_len) < MIN_BODY);

    // Load the refill length on a short redirect, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n)                   remain <= '0;
        else if (load && short_body)  remain <= SW'(MIN_BODY - int'(body_len));
        else if (remain != '0)        remain <= remain - SW'(1);
    end

    assign stall = (remain != '0);

    a_r9_stall_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (remain != '0 && !load) |=> remain == $past(remain) - SW'(1));
endmodule

// File: rtl/zol_sequencer.sv
// Zero-overhead loop sequencer top. It joins the frame stack, the end-address
// matcher and the refill timer. Assumes loop_count_i is non-zero and that the
// core follows redirect_o on the next fetch and holds fetch while stall_o.
module zol_sequencer
    import zol_pkg::*;
#(
    parameter int DEPTH    = 6,
    parameter int MIN_BODY = 3,
    localparam int SPW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    input  logic              loop_start_i,
    input  logic [CNT_W-1:0]  loop_count_i,
    input  logic [ADDR_W-1:0] loop_end_i,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] redirect_pc_o,
    output logic              expired_o,
    output logic              stall_o,
    output logic              overflow_o,
    output logic [SPW-1:0]    loop_depth_o
);
    loop_frame_t       frames [DEPTH];
    loop_frame_t       new_frame;
    logic [SPW-1:0]    sp, pops, base;
    logic [ADDR_W-1:0] body_len;
    logic              active, push_en, full_after_pop;

    assign active         = fetch_valid_i && !stall_o;
    assign base           = sp - pops;
    assign full_after_pop = (base == SPW'(DEPTH));
    assign push_en        = active && loop_start_i && !full_after_pop;
    assign overflow_o     = active && loop_start_i && full_after_pop;
    assign expired_o      = (pops != '0);
    assign loop_depth_o   = sp;

    // Frame for a new loop: body begins right after the command.
    always_comb begin
        new_frame.count      = loop_count_i;
        new_frame.start_addr = fetch_pc_i + ADDR_W'(1);
        new_frame.end_addr   = loop_end_i;
    end

    zol_endcheck #(.DEPTH(DEPTH)) u_match (
        .active   (active),
        .pc       (fetch_pc_i),
        .frames   (frames),
        .sp       (sp),
        .pops     (pops),
        .redirect (redirect_o),
        .target   (redirect_pc_o),
        .body_len (body_len)
    );

    zol_stack #(.DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .pops       (pops),
        .dec_en     (redirect_o),
        .push_en    (push_en),
        .push_frame (new_frame),
        .frames     (frames),
        .sp         (sp)
    );

    zol_refill #(.MIN_BODY(MIN_BODY)) u_refill (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (redirect_o),
        .body_len (body_len),
        .stall    (stall_o)
    );

    a_r7_overflow_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && pops == '0) |=> loop_depth_o == $past(loop_depth_o));

    a_r3_redirect_needs_loop: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> loop_depth_o != '0);

    a_r4_expire_needs_loop: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> loop_depth_o != '0);

    a_r9_short_body_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && int'(body_len) < MIN_BODY) |=> stall_o);
endmodule

// File: tb/tb_zol_sequencer.sv
// Directed bench: a small fetch model follows redirects and stalls and
// counts visits per address, expiries, redirects, stalls and cycles.
module tb_zol_sequencer;
    import zol_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_valid_i = 1'b0;
    logic [ADDR_W-1:0] fetch_pc_i = '0;
    logic              loop_start_i = 1'b0;
    logic [CNT_W-1:0]  loop_count_i = '0;
    logic [ADDR_W-1:0] loop_end_i = '0;
    logic              redirect_o, expired_o, stall_o, overflow_o;
    logic [ADDR_W-1:0] redirect_pc_o;
    logic [2:0]        loop_depth_o;

    always #2 clk = ~clk;   // 250 MHz

    zol_sequencer dut (.*);

    int n_checks = 0, n_fail = 0;
    int visits [256];
    int cyc, n_exp, n_redir, n_stall, n_ovf;
    int cmd_pc [8], cmd_cnt [8], cmd_end [8];
    int n_cmd;

    task automatic chk(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fetch_valid_i = 1'b0; loop_start_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run the fetch model from pc0 until pc reaches stop_pc.
    task automatic run(int pc0, int stop_pc);
        int pc;
        pc = pc0;
        cyc = 0; n_exp = 0; n_redir = 0; n_stall = 0; n_ovf = 0;
        for (int i = 0; i < 256; i++) visits[i] = 0;
        while (pc != stop_pc && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            fetch_valid_i = 1'b1;
            fetch_pc_i    = ADDR_W'(pc);
            loop_start_i  = 1'b0;
            for (int c = 0; c < n_cmd; c++) begin
                if (cmd_pc[c] == pc) begin
                    loop_start_i = 1'b1;
                    loop_count_i = CNT_W'(cmd_cnt[c]);
                    loop_end_i   = ADDR_W'(cmd_end[c]);
                end
            end
            #1;
            if (stall_o) begin
                n_stall++;
                if (redirect_o || expired_o) n_redir += 1000;
            end else begin
                visits[pc[7:0]]++;
                if (expired_o)  n_exp++;
                if (overflow_o) n_ovf++;
                if (redirect_o) begin n_redir++; pc = int'(redirect_pc_o); end
                else pc = pc + 1;
            end
        end
        @(negedge clk);
        fetch_valid_i = 1'b0; loop_start_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1", int'(loop_depth_o), 0, "depth after reset");
        chk("R1", int'(redirect_o), 0, "redirect after reset");
        chk("R1", int'(stall_o), 0, "stall after reset");
    endtask

    task automatic t_single();
        n_cmd = 1; cmd_pc[0] = 10; cmd_cnt[0] = 5; cmd_end[0] = 14;
        run(10, 16);
        chk("R2", visits[10], 1, "command fetched once");
        chk("R2", visits[11], 5, "body start visits");
        chk("R5", visits[12], 5, "no redirect before end");
        chk("R3", n_redir, 4, "redirect count");
        chk("R4", visits[14], 5, "end visits");
        chk("R4", visits[15], 1, "fall-through visit");
        chk("R4", n_exp, 1, "expiry count");
        chk("R4", cyc, 22, "cycles, no overhead");
        chk("R9", n_stall, 0, "no stall for long body");
        chk("R4", int'(loop_depth_o), 0, "depth after loop");
    endtask

    task automatic t_one_pass();
        n_cmd = 1; cmd_pc[0] = 20; cmd_cnt[0] = 1; cmd_end[0] = 22;
        run(20, 24);
        chk("R11", visits[21], 1, "single pass body");
        chk("R11", n_exp, 1, "expired on first end");
        chk("R11", cyc, 4, "cycles");
    endtask

    task automatic t_nested();
        n_cmd = 2;
        cmd_pc[0] = 30; cmd_cnt[0] = 3; cmd_end[0] = 40;
        cmd_pc[1] = 31; cmd_cnt[1] = 4; cmd_end[1] = 35;
        run(30, 42);
        chk("R6", visits[31], 3, "inner command per outer pass");
        chk("R6", visits[32], 12, "inner body visits");
        chk("R6", visits[40], 3, "outer end visits");
        chk("R6", n_exp, 4, "expiries");
        chk("R6", cyc, 68, "cycles");
    endtask

    task automatic t_shared_end();
        n_cmd = 2;
        cmd_pc[0] = 50; cmd_cnt[0] = 2; cmd_end[0] = 56;
        cmd_pc[1] = 51; cmd_cnt[1] = 3; cmd_end[1] = 56;
        run(50, 58);
        chk("R8", visits[51], 2, "outer restarts at its start");
        chk("R8", visits[52], 6, "inner body visits");
        chk("R8", visits[57], 1, "fall-through once");
        chk("R8", n_exp, 2, "expiry cycles");
        chk("R8", cyc, 34, "cycles");
        chk("R8", int'(loop_depth_o), 0, "both frames popped");
    endtask

    task automatic t_short_body();
        n_cmd = 1; cmd_pc[0] = 60; cmd_cnt[0] = 4; cmd_end[0] = 61;
        run(60, 63);
        chk("R9", n_stall, 6, "stall cycles, 1-instr body");
        chk("R10", visits[61], 4, "end ignored during stall");
        chk("R10", n_redir, 3, "no redirect during stall");
        chk("R9", cyc, 12, "cycles, 1-instr body");
        n_cmd = 1; cmd_pc[0] = 70; cmd_cnt[0] = 3; cmd_end[0] = 72;
        run(70, 74);
        chk("R9", n_stall, 2, "stall cycles, 2-instr body");
        chk("R9", visits[71], 3, "2-instr body passes");
    endtask

    task automatic t_overflow();
        n_cmd = 7;
        for (int c = 0; c < 7; c++) begin
            cmd_pc[c] = 80 + c; cmd_cnt[c] = 2; cmd_end[c] = 200 - c;
        end
        run(80, 87);
        chk("R7", n_ovf, 1, "overflow flagged once");
        chk("R6", int'(loop_depth_o), 6, "six levels held");
        chk("R7", int'(loop_depth_o), 6, "depth unchanged by refused push");
        do_reset();
        #1;
        chk("R1", int'(loop_depth_o), 0, "reset clears full stack");
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        n_cmd = 0;
        t_reset();
        t_single();
        t_one_pass();
        t_nested();
        t_shared_end();
        t_short_body();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule